// File: doc/BRIEF.md
# Successive Approximation Register

This block sequences and stores the bit trials of a successive approximation analog-to-digital loop. A start request loads the most significant bit as the first trial. On each following clock the comparator answer `d` either keeps or drops the bit under trial, and the next lower bit becomes the new trial. The parallel code `q` drives an external DAC. Each decided bit also appears on `sout` in the cycle it is resolved, and `eoc` flags a finished code. All inputs are sampled on the rising edge of `clk`.

A build-time parameter `VARIANT` gives the line `ctl` one of two meanings. With `VARIANT=0`, `ctl` is a synchronous clear, and a start needs a fresh rising edge on `sc` or a clear that has just been released. With `VARIANT=1`, `ctl` enables early termination: while it is high, the conversion ends once bit `stop_pos` is resolved. This variant also restarts whenever `sc` is high while a result is held.

No port of this block carries a stream with a handshake. The result has no back-pressure: once `eoc` is high, `q` stays unchanged until the next start (or a clear), so a consumer may read it at any time before then. `rst_n` is an asynchronous, active-low power-on reset.

Top module: `sar_engine`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `q` is all zeros, `eoc` is 1 and `sout` is 0.
- R2: The clock edge that starts a conversion leaves `q` equal to 1 followed by WIDTH-1 zeros (0x80 for 8 bits), with `eoc`=0 and `sout`=0.
- R3: Each continuing edge during a conversion sets the bit under trial to `d` and, unless the conversion ends, sets the next lower bit to 1. When the comparator reports `d`=1 exactly for trial codes not above a target, a full conversion ends with `q` equal to that target.
- R4: On each continuing edge, `sout` takes the value of `d` sampled at that edge, i.e. the decided value of the bit just resolved.
- R5: A full-length conversion sets `eoc` on the eighth continuing edge after the start, which resolves bit 0, and not earlier.
- R6: With VARIANT=0, `ctl`=1 at an edge clears `q` to zero, sets `eoc` to 1 and clears `sout`, whatever `sc` is.
- R7: With VARIANT=0, `sc`=1 at an edge where `ctl` is 0 starts a conversion if `sc` was 0 at the previous edge or `ctl` was 1 at the previous edge.
- R8: With VARIANT=0, holding `sc` at 1 does not restart a running conversion, and once `eoc` is 1 the result and `eoc` stay unchanged until a new start or clear.
- R9: With VARIANT=1 and `eoc`=0, a rising `sc` (1 now, 0 at the previous edge) restarts the conversion; `sc` that stays high, or stays low, lets the conversion continue.
- R10: With VARIANT=1 and `eoc`=1, `sc`=0 keeps `q`, `sout` and `eoc` unchanged, while `sc`=1 starts a new conversion at that edge.
- R11: With VARIANT=1 and `ctl`=1, `eoc` sets on the edge that resolves bit `stop_pos`, after 8 minus `stop_pos` continuing edges, and bits below `stop_pos` stay 0.
- R12: With VARIANT=1 and `ctl`=0, `stop_pos` has no effect and the conversion runs the full eight trials.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sc | input | 1 | Start-conversion request |
| d | input | 1 | Comparator result for the current trial code (1 = keep bit) |
| ctl | input | 1 | Synchronous clear (VARIANT=0) or early-termination enable (VARIANT=1) |
| stop_pos | input | $clog2(WIDTH) | Index of the last bit to resolve when early termination is enabled |
| q | output | WIDTH | Parallel trial / result code, MSB first |
| sout | output | 1 | Decided value of the bit resolved at the last edge |
| eoc | output | 1 | Conversion finished, result held |

## Verification
The assertions check on every cycle that a start loads the MSB trial pattern and clears `eoc`, and that a clear empties the register. They also check that `sout` follows the sampled comparator bit on continuing edges and that a held result neither changes nor drops `eoc` without a start. Only the bench scenarios can show the whole trial sequence. These cover the final code matching the target, `eoc` rising on exactly the right edge for full and shortened lengths, `stop_pos` being ignored when early termination is off, and the retrigger rules for a held-high `sc` and a just-released clear.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_START = 2'd2,
    ACT_STEP  = 2'd3
  } sar_act_e;
endpackage

// File: rtl/sar_history.sv
module sar_history (
  input  logic clk,
  input  logic rst_n,
  input  logic sc,
  input  logic ctl,
  output logic sc_prev,
  output logic ctl_prev
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_prev  <= 1'b0;
      ctl_prev <= 1'b0;
    end else begin
      sc_prev  <= sc;
      ctl_prev <= ctl;
    end
  end
endmodule

// File: rtl/sar_act_decode.sv
module sar_act_decode #(
  parameter int VARIANT = 0
) (
  input  logic              sc,
  input  logic              ctl,
  input  logic              sc_prev,
  input  logic              ctl_prev,
  input  logic              done,
  output sar_pkg::sar_act_e act
);
  import sar_pkg::*;

  always_comb begin
    act = ACT_HOLD;
    if (VARIANT == 0) begin
      // clear line wins; start needs a fresh request or a released clear
      if (ctl)
        act = ACT_CLEAR;
      else if (sc && (!sc_prev || ctl_prev))
        act = ACT_START;
      else if (!done)
        act = ACT_STEP;
    end else begin
      // retriggerable: a held result restarts on any high request
      if (done)
        act = sc ? ACT_START : ACT_HOLD;
      else if (sc && !sc_prev)
        act = ACT_START;
      else
        act = ACT_STEP;
    end
  end
endmodule

// File: rtl/sar_shift_core.sv
module sar_shift_core #(
  parameter int WIDTH = 8,
  localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sar_pkg::sar_act_e act,
  input  logic              d,
  input  logic [IDXW-1:0]   stop,
  output logic [WIDTH-1:0]  q,
  output logic              sout,
  output logic              eoc
);
  import sar_pkg::*;

  localparam logic [IDXW-1:0]  TOP_IDX = IDXW'(WIDTH - 1);
  localparam logic [WIDTH-1:0] MSB_ONE = {1'b1, {(WIDTH-1){1'b0}}};

  logic [IDXW-1:0] idx;
  logic [IDXW-1:0] idx_dn;

  assign idx_dn = idx - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= '0;
      idx  <= TOP_IDX;
      eoc  <= 1'b1;
      sout <= 1'b0;
    end else begin
      case (act)
        ACT_CLEAR: begin
          q    <= '0;
          idx  <= TOP_IDX;
          eoc  <= 1'b1;
          sout <= 1'b0;
        end
        ACT_START: begin
          q    <= MSB_ONE;
          idx  <= TOP_IDX;
          eoc  <= 1'b0;
          sout <= 1'b0;
        end
        ACT_STEP: begin
          q[idx] <= d;
          sout   <= d;
          if (idx <= stop) begin
            eoc <= 1'b1;
          end else begin
            q[idx_dn] <= 1'b1;
            idx       <= idx_dn;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int WIDTH   = 8,
  parameter int VARIANT = 0,
  localparam int IDXW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sc,
  input  logic             d,
  input  logic             ctl,
  input  logic [IDXW-1:0]  stop_pos,
  output logic [WIDTH-1:0] q,
  output logic             sout,
  output logic             eoc
);
  import sar_pkg::*;

  logic            sc_prev;
  logic            ctl_prev;
  logic [IDXW-1:0] stop;
  sar_act_e        act;

  // last bit to resolve: bit 0 unless early termination is on
  always_comb begin
    if (VARIANT == 1 && ctl)
      stop = stop_pos;
    else
      stop = '0;
  end

  sar_history u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .sc       (sc),
    .ctl      (ctl),
    .sc_prev  (sc_prev),
    .ctl_prev (ctl_prev)
  );

  sar_act_decode #(.VARIANT(VARIANT)) u_dec (
    .sc       (sc),
    .ctl      (ctl),
    .sc_prev  (sc_prev),
    .ctl_prev (ctl_prev),
    .done     (eoc),
    .act      (act)
  );

  sar_shift_core #(.WIDTH(WIDTH)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .d     (d),
    .stop  (stop),
    .q     (q),
    .sout  (sout),
    .eoc   (eoc)
  );
endmodule

// File: rtl/sar_engine_chk.sv
module sar_engine_chk #(
  parameter int WIDTH   = 8,
  parameter int VARIANT = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sc,
  input logic             ctl,
  input logic             d,
  input logic [WIDTH-1:0] q,
  input logic             sout,
  input logic             eoc
);
  localparam logic [WIDTH-1:0] MSB_ONE = {1'b1, {(WIDTH-1){1'b0}}};

  logic sc_d, ctl_d;
  logic start_c, clear_c, step_c, hold_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_d  <= 1'b0;
      ctl_d <= 1'b0;
    end else begin
      sc_d  <= sc;
      ctl_d <= ctl;
    end
  end

  always_comb begin
    if (VARIANT == 0) begin
      clear_c = ctl;
      start_c = !ctl && sc && (!sc_d || ctl_d);
    end else begin
      clear_c = 1'b0;
      start_c = sc && (eoc || !sc_d);
    end
    step_c = !clear_c && !start_c && !eoc;
    hold_c = !clear_c && !start_c && eoc;
  end

  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_state_r1: assert (q == '0 && eoc && !sout);
    end
  end

  p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (q == MSB_ONE && !eoc && !sout));

  p_sout_follows_d_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_c |=> (sout == $past(d)));

  // R8 for VARIANT=0, R10 for VARIANT=1
  p_result_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_c |=> ($stable(q) && $stable(sout) && eoc));

  generate
    if (VARIANT == 0) begin : g_clear
      p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_c |=> (q == '0 && eoc && !sout));
    end
  endgenerate
endmodule

bind sar_engine sar_engine_chk #(.WIDTH(WIDTH), .VARIANT(VARIANT)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .sc    (sc),
  .ctl   (ctl),
  .d     (d),
  .q     (q),
  .sout  (sout),
  .eoc   (eoc)
);

// File: tb/sar_engine_test.sv
module sar_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sc0 = 1'b0, mr0 = 1'b0, d0 = 1'b0;
  logic sc1 = 1'b0, ff1 = 1'b0, d1 = 1'b0;
  logic [2:0] stop1 = 3'd0;
  logic [7:0] q0, q1;
  logic sout0, sout1, eoc0, eoc1;

  int tgt0 = 0, tgt1 = 0;
  int n_checks = 0, n_fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state, index 0 = clear variant, 1 = shortening variant
  int mq[2];
  int midx[2];
  bit meoc[2], msout[2], mscp[2], mctlp[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_engine #(.WIDTH(8), .VARIANT(0)) uut (
    .clk(clk), .rst_n(rst_n), .sc(sc0), .d(d0), .ctl(mr0), .stop_pos(3'd0),
    .q(q0), .sout(sout0), .eoc(eoc0));

  sar_engine #(.WIDTH(8), .VARIANT(1)) uut_ff (
    .clk(clk), .rst_n(rst_n), .sc(sc1), .d(d1), .ctl(ff1), .stop_pos(stop1),
    .q(q1), .sout(sout1), .eoc(eoc1));

  task automatic model_upd(input int v, input bit s, input bit c, input bit dd, input int stp);
    int last;
    int act; // 0 hold, 1 clear, 2 start, 3 step
    act = 0;
    if (v == 0) begin
      if (c) act = 1;
      else if (s && (!mscp[v] || mctlp[v])) act = 2;
      else if (!meoc[v]) act = 3;
    end else begin
      if (meoc[v]) act = s ? 2 : 0;
      else if (s && !mscp[v]) act = 2;
      else act = 3;
    end
    last = (v == 1 && c) ? stp : 0;
    if (act == 1) begin
      mq[v] = 0; midx[v] = 7; meoc[v] = 1; msout[v] = 0;
    end else if (act == 2) begin
      mq[v] = 128; midx[v] = 7; meoc[v] = 0; msout[v] = 0;
    end else if (act == 3) begin
      if (!dd) mq[v] = mq[v] & ~(1 << midx[v]);
      msout[v] = dd;
      if (midx[v] <= last) meoc[v] = 1;
      else begin
        midx[v] = midx[v] - 1;
        mq[v] = mq[v] | (1 << midx[v]);
      end
    end
    mscp[v] = s;
    mctlp[v] = c;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < 2; v++) begin
        mq[v] = 0; midx[v] = 7; meoc[v] = 1; msout[v] = 0; mscp[v] = 0; mctlp[v] = 0;
      end
    end else begin
      model_upd(0, sc0, mr0, d0, 0);
      model_upd(1, sc1, ff1, d1, int'(stop1));
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({cur_req, " cycle uut"}, {int'(q0), 7'd0, sout0, 7'd0, eoc0},
            {mq[0], 7'd0, msout[0], 7'd0, meoc[0]});
      check({cur_req, " cycle uut_ff"}, {int'(q1), 7'd0, sout1, 7'd0, eoc1},
            {mq[1], 7'd0, msout[1], 7'd0, meoc[1]});
    end
  end

  task automatic cyc(input bit s0, input bit m0, input bit s1, input bit f1);
    sc0 = s0; mr0 = m0; sc1 = s1; ff1 = f1;
    @(posedge clk);
    #2;
    d0 = (int'(q0) <= tgt0);
    d1 = (int'(q1) <= tgt1);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL %s watchdog: actual %0d cycles expected fewer", cur_req, WD_CYCLES);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check("R1 q0", int'(q0), 0);   check("R1 eoc0", int'(eoc0), 1); check("R1 sout0", int'(sout0), 0);
    check("R1 q1", int'(q1), 0);   check("R1 eoc1", int'(eoc1), 1);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0);
    check("R1 held after release", int'(q0), 0);

    // R2 R3 R4 R5: full conversion of 0xA5, sc pulsed once
    cur_req = "R3";
    tgt0 = 'hA5;
    cyc(1, 0, 0, 0);
    check("R2 start code", int'(q0), 'h80);
    check("R2 start eoc", int'(eoc0), 0);
    for (int i = 0; i < 8; i++) begin
      cyc(0, 0, 0, 0);
      check("R4 sout bit", int'(sout0), (tgt0 >> (7 - i)) & 1);
      if (i == 6) check("R5 eoc not early", int'(eoc0), 0);
    end
    check("R5 eoc after bit0", int'(eoc0), 1);
    check("R3 result", int'(q0), 'hA5);

    // R8: held sc does not restart, result held afterwards
    cur_req = "R8";
    tgt0 = 'h3C;
    cyc(1, 0, 0, 0);
    for (int i = 0; i < 9; i++) cyc(1, 0, 0, 0);
    check("R8 held-sc result", int'(q0), 'h3C);
    check("R8 held-sc eoc", int'(eoc0), 1);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0);
    check("R8 result kept", int'(q0), 'h3C);

    // R6: clear mid conversion with sc high
    cur_req = "R6";
    tgt0 = 'hFF;
    cyc(1, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0);
    cyc(1, 1, 0, 0);
    check("R6 clear q", int'(q0), 0);
    check("R6 clear eoc", int'(eoc0), 1);
    check("R6 clear sout", int'(sout0), 0);

    // R7: start right after clear released, sc held high throughout
    cur_req = "R7";
    cyc(1, 1, 0, 0);
    tgt0 = 'h01;
    cyc(1, 0, 0, 0);
    check("R7 start after clear", int'(q0), 'h80);
    check("R7 eoc low", int'(eoc0), 0);
    for (int i = 0; i < 8; i++) cyc(1, 0, 0, 0);
    check("R7 result", int'(q0), 'h01);
    cyc(0, 0, 0, 0);

    // R12: shortening variant, ff off, stop_pos ignored
    cur_req = "R12";
    tgt1 = 'h5A; stop1 = 3'd5;
    cyc(0, 0, 1, 0);
    for (int i = 0; i < 7; i++) cyc(0, 0, 0, 0);
    check("R12 not early", int'(eoc1), 0);
    cyc(0, 0, 0, 0);
    check("R12 full result", int'(q1), 'h5A);
    check("R12 eoc", int'(eoc1), 1);

    // R10: held result, then retrigger
    cur_req = "R10";
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0);
    check("R10 retained", int'(q1), 'h5A);
    check("R10 eoc kept", int'(eoc1), 1);
    tgt1 = 0;
    cyc(0, 0, 1, 0);
    check("R10 retrigger", int'(q1), 'h80);
    check("R10 retrigger eoc", int'(eoc1), 0);
    cyc(0, 0, 1, 0);
    for (int i = 0; i < 7; i++) cyc(0, 0, 0, 0);
    check("R10 result", int'(q1), 0);

    // R9: rising sc mid conversion restarts
    cur_req = "R9";
    tgt1 = 'hC3;
    cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    check("R9 continuing", int'(eoc1), 0);
    cyc(0, 0, 1, 0);
    check("R9 restart", int'(q1), 'h80);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0);
    check("R9 result", int'(q1), 'hC3);

    // R11: early termination
    cur_req = "R11";
    tgt1 = 'hB7; stop1 = 3'd3;
    cyc(0, 0, 1, 1);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1);
    check("R11 not yet", int'(eoc1), 0);
    cyc(0, 0, 0, 1);
    check("R11 eoc at stop", int'(eoc1), 1);
    check("R11 short result", int'(q1), 'hB0);
    stop1 = 3'd7;
    cyc(0, 0, 1, 1);
    cyc(0, 0, 0, 1);
    check("R11 one trial eoc", int'(eoc1), 1);
    check("R11 one trial q", int'(q1), 'h80);
    tgt1 = 'h6E; stop1 = 3'd0;
    cyc(0, 0, 1, 1);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 1);
    check("R11 stop zero", int'(q1), 'h6E);

    cyc(0, 0, 0, 0);
    finish_run();
  end
endmodule